// File: doc/BRIEF.md
# BCD Calendar Counter with Hold Handshake

The block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 2000 to 2099. It runs from a slow-clock strobe (`tick_32k`). This strobe is one system-clock cycle wide and occurs at the 32.768 kHz rate. A prescaler divides the strobe down to one advance per second. The date logic applies month lengths and leap years.

Software controls the block through a simple byte register port. To set the time, it first asks the counter to pause and waits for the pause acknowledge. It then fills a bank of writable time registers. Finally it clears the pause request, and at that moment the counter loads the new time and starts its second from zero. The running count is read from a separate bank, which is live and can change between two field reads. A reader therefore samples the seconds field again to detect a tick that landed in the middle of a read.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every control bit reads 0. The live time is 00:00:00 with weekday 0, day 0x01, month 0x01 and year 0x00.
- R2: Bit 7 of the control register at offset 0x00 enables counting. When it is 0 the live time does not change. When it is 1 the seconds advance once per PRESCALE strobes.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. Each wraps to 0x00 and carries into the next field.
- R4: When bit 5 of offset 0x00 is 1 (24-hour format), hours run from 0x00 to 0x23. Leaving 0x23 wraps to 0x00 and advances the day.
- R5: When bit 5 of offset 0x00 is 0 (12-hour format), hours hold BCD 1 to 12 in bits 4:0 with bit 5 as the PM flag. 0x12 goes to 0x01. 11 AM (0x11) goes to 12 PM (0x32). 11 PM (0x31) goes to 12 AM (0x12) and advances the day.
- R6: The day wraps to 0x01 after the last day of its month: 31, 30 for months 4, 6, 9 and 11, and for month 2 either 28, or 29 when the year is a multiple of 4 (year 00 included).
- R7: The month wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00.
- R8: The weekday (0 to 6) advances once per day and wraps from 6 to 0.
- R9: Writing 1 to bit 0 of offset 0x08 raises the pause request, which reads back on bit 0 at once. The acknowledge, bit 1, rises HOLD_TICKS strobes later. While either bit is set the live time does not advance.
- R10: Writing 0 to offset 0x08 while the acknowledge is set does three things on that edge: it loads the write bank into the live time, it clears both flags, and it clears the prescaler. The next second then falls PRESCALE strobes later.
- R11: Clearing the request before the acknowledge has risen cancels the pause and loads nothing.
- R12: The write bank sits at offsets 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C (seconds, minutes, hours, weekday, day, month, year) and reads back what was written. The live bank is in the same order at 0x4C to 0x64. Read data is registered and appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe at the slow-clock rate |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The hardest cases to reach are the carries that only happen at the end of a day, month or year: 23:59:59 on 31 December 99, the 28th of February in a leap year and in a common year, and 11 PM in 12-hour format. Waiting for these from reset is impractical. The stimulus instead uses the pause handshake to load a time one or two seconds before each boundary, then enables counting. Because the release clears the prescaler, each read can be placed in a window where the number of elapsed seconds is exact.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int FIELD_W = 8;
  localparam int NFIELD  = 7;
  localparam int FIDX_W  = $clog2(NFIELD);

  // register map (byte offsets)
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_HOLD   = 8'h08;
  localparam logic [7:0] OFS_WBANK  = 8'h14;
  localparam logic [7:0] OFS_LBANK  = 8'h4C;
  localparam logic [7:0] BANK_SPAN  = 8'(4 * (NFIELD - 1));

  typedef struct packed {
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] wday;
    logic [FIELD_W-1:0] day;
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] year;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                 wday: 8'h00, day: 8'h01, mon: 8'h01,
                                 year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] field_of(input cal_t c, input logic [FIDX_W-1:0] i);
    case (i)
      3'd0:    field_of = c.sec;
      3'd1:    field_of = c.min;
      3'd2:    field_of = c.hour;
      3'd3:    field_of = c.wday;
      3'd4:    field_of = c.day;
      3'd5:    field_of = c.mon;
      default: field_of = c.year;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PRESCALE = 32768,
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          clear,
  output logic          sec_pulse,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)           cnt_q <= '0;
    else if (run && tick)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign sec_pulse = run && tick && (cnt_q == LAST);
  assign count_o   = cnt_q;
endmodule

// File: rtl/rtc_hold_ctrl.sv
`timescale 1ns/1ps
module rtc_hold_ctrl #(
  parameter int HOLD_TICKS = 2,
  localparam int CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wr,
  input  logic wr_val,
  output logic req_o,
  output logic ack_o,
  output logic load_o
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic          req_q, ack_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else if (wr) begin
      if (wr_val) begin
        if (!req_q) begin
          req_q <= 1'b1;
          cnt_q <= '0;
        end
      end else begin
        req_q <= 1'b0;
        ack_q <= 1'b0;
        cnt_q <= '0;
      end
    end else if (req_q && !ack_q && tick) begin
      if (cnt_q == LAST) ack_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o  = req_q;
  assign ack_o  = ack_q;
  assign load_o = wr && !wr_val && ack_q;
endmodule

// File: rtl/rtc_cal_advance.sv
`timescale 1ns/1ps
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  input  logic mode24,
  output cal_t nxt
);
  logic       sec_wrap, min_wrap, day_step, day_wrap, mon_wrap;
  logic [7:0] last_day, h12_inc;
  logic [4:0] leap_sum;
  logic       leap;

  always_comb begin
    nxt      = cur;
    sec_wrap = (cur.sec == 8'h59);
    nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);

    min_wrap = 1'b0;
    if (sec_wrap) begin
      min_wrap = (cur.min == 8'h59);
      nxt.min  = min_wrap ? 8'h00 : bcd_inc(cur.min);
    end

    day_step = 1'b0;
    h12_inc  = bcd_inc({3'b000, cur.hour[4:0]});
    if (min_wrap) begin
      if (mode24) begin
        day_step = (cur.hour == 8'h23);
        nxt.hour = day_step ? 8'h00 : bcd_inc(cur.hour);
      end else if (cur.hour[4:0] == 5'h12) begin
        nxt.hour = {2'b00, cur.hour[5], 5'h01};
      end else if (cur.hour[4:0] == 5'h11) begin
        nxt.hour = {2'b00, ~cur.hour[5], 5'h12};
        day_step = cur.hour[5];
      end else begin
        nxt.hour = {2'b00, cur.hour[5], h12_inc[4:0]};
      end
    end

    // leap: ten*10+one divisible by 4 <=> (2*ten+one) divisible by 4
    leap_sum = {cur.year[7:4], 1'b0} + {1'b0, cur.year[3:0]};
    leap     = (leap_sum[1:0] == 2'b00);
    case (cur.mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase

    day_wrap = 1'b0;
    if (day_step) begin
      nxt.wday = (cur.wday >= 8'h06) ? 8'h00 : cur.wday + 8'h01;
      day_wrap = (cur.day == last_day);
      nxt.day  = day_wrap ? 8'h01 : bcd_inc(cur.day);
    end

    mon_wrap = 1'b0;
    if (day_wrap) begin
      mon_wrap = (cur.mon == 8'h12);
      nxt.mon  = mon_wrap ? 8'h01 : bcd_inc(cur.mon);
    end

    if (mon_wrap) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE   = 32768,
  parameter int HOLD_TICKS = 2,
  parameter int ADDR_W     = 8,
  localparam int PRESC_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFS_HOLD);
  localparam logic [ADDR_W-1:0] A_WB   = ADDR_W'(OFS_WBANK);
  localparam logic [ADDR_W-1:0] A_LB   = ADDR_W'(OFS_LBANK);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(BANK_SPAN);

  logic run_q, mode24_q;
  cal_t cal_q, cal_nxt, cal_load;
  logic [7:0] wbank [NFIELD];

  logic               hold_wr, req, ack, load, stopped, sec_pulse;
  logic [PRESC_W-1:0] presc_cnt;

  // address decode
  logic [ADDR_W-1:0] woff, loff;
  logic              wb_hit, lb_hit;
  logic [FIDX_W-1:0] wb_idx, lb_idx;

  assign woff   = bus_addr - A_WB;
  assign loff   = bus_addr - A_LB;
  assign wb_hit = (bus_addr >= A_WB) && (bus_addr <= A_WB + SPAN) && (bus_addr[1:0] == 2'b00);
  assign lb_hit = (bus_addr >= A_LB) && (bus_addr <= A_LB + SPAN) && (bus_addr[1:0] == 2'b00);
  assign wb_idx = woff[FIDX_W+1:2];
  assign lb_idx = loff[FIDX_W+1:2];
  assign hold_wr = bus_we && (bus_addr == A_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      mode24_q <= 1'b0;
    end else if (bus_we && bus_addr == A_CTRL) begin
      run_q    <= bus_wdata[7];
      mode24_q <= bus_wdata[5];
    end
  end

  // writable time bank
  for (genvar g = 0; g < NFIELD; g++) begin : g_wbank
    always_ff @(posedge clk) begin
      if (rst)                                          wbank[g] <= field_of(CAL_RESET, FIDX_W'(g));
      else if (bus_we && wb_hit && wb_idx == FIDX_W'(g)) wbank[g] <= bus_wdata;
    end
  end

  assign cal_load = '{sec: wbank[0], min: wbank[1], hour: wbank[2], wday: wbank[3],
                      day: wbank[4], mon: wbank[5], year: wbank[6]};

  rtc_hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick_32k),
    .wr(hold_wr), .wr_val(bus_wdata[0]),
    .req_o(req), .ack_o(ack), .load_o(load)
  );

  assign stopped = req || ack;

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst(rst), .tick(tick_32k),
    .run(run_q && !stopped), .clear(load),
    .sec_pulse(sec_pulse), .count_o(presc_cnt)
  );

  rtc_cal_advance u_adv (.cur(cal_q), .mode24(mode24_q), .nxt(cal_nxt));

  always_ff @(posedge clk) begin
    if (rst)            cal_q <= CAL_RESET;
    else if (load)      cal_q <= cal_load;
    else if (sec_pulse) cal_q <= cal_nxt;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= 8'h00;
    else if (bus_addr == A_CTRL) bus_rdata <= {run_q, 1'b0, mode24_q, 5'b00000};
    else if (bus_addr == A_HOLD) bus_rdata <= {6'b000000, ack, req};
    else if (wb_hit)             bus_rdata <= wbank[wb_idx];
    else if (lb_hit)             bus_rdata <= field_of(cal_q, lb_idx);
    else                         bus_rdata <= 8'h00;
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk #(
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          req,
  input logic          ack,
  input logic          load,
  input logic          sec_pulse,
  input logic [PW-1:0] presc_cnt,
  input logic [55:0]   live
);
  logic [7:0] sec, wday;
  assign sec  = live[55:48];
  assign wday = live[31:24];

  // R9: acknowledge never stands without a request
  p_ack_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    ack |-> req);

  // R9: a paused counter keeps its value
  p_held_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (req || ack) && !load |=> $stable(live));

  // R2: disabled counter keeps its value
  p_run_off_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !run && !load |=> $stable(live));

  // R3: seconds wrap from 59 to 00
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    sec_pulse && !load && sec == 8'h59 |=> sec == 8'h00);

  // R3: seconds field stays valid BCD below 60
  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (rst)
    (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5));

  // R8: weekday never leaves 0..6
  p_wday_range_r8: assert property (@(posedge clk) disable iff (rst)
    wday <= 8'h06);

  // R10: release restarts the second from zero
  p_presc_clear_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> presc_cnt == '0);
endmodule

bind rtc_calendar rtc_calendar_chk #(.PW(PRESC_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .req(req), .ack(ack), .load(load),
  .sec_pulse(sec_pulse), .presc_cnt(presc_cnt), .live(cal_q)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int PRESCALE = 8;
  localparam int TICK_DIV = 4;
  localparam int SEC_CYC  = PRESCALE * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  logic rd_issued = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_calendar #(.PRESCALE(PRESCALE), .HOLD_TICKS(2), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // slow-clock strobe: one cycle in every TICK_DIV
  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    tick_32k = 1'b1;
    @(negedge clk);
    tick_32k = 1'b0;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  initial forever begin
    @(posedge clk);
    if (rd_issued) begin
      #5;
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_issued = 1'b1;
    @(negedge clk);
    rd_issued = 1'b0;
  endtask

  task automatic load_time(input logic [7:0] s, m, h, w, d, mo, y);
    wr(8'h08, 8'h01);
    repeat (12) @(negedge clk);
    wr(8'h14, s); wr(8'h18, m); wr(8'h1C, h); wr(8'h20, w);
    wr(8'h24, d); wr(8'h28, mo); wr(8'h2C, y);
    wr(8'h08, 8'h00);
  endtask

  task automatic expect_time(input logic [7:0] s, m, h, w, d, mo, y, input string tag);
    rd(8'h4C, s, {tag, " sec"});
    rd(8'h50, m, {tag, " min"});
    rd(8'h54, h, {tag, " hour"});
    rd(8'h58, w, {tag, " wday"});
    rd(8'h5C, d, {tag, " day"});
    rd(8'h60, mo, {tag, " month"});
    rd(8'h64, y, {tag, " year"});
  endtask

  // enable counting in the given format, wait n whole seconds
  task automatic run_secs(input logic mode24, input int n);
    wr(8'h00, {1'b1, 1'b0, mode24, 5'b0});
    repeat (SEC_CYC * n + 4) @(negedge clk);
  endtask

  task automatic stop_run(input logic mode24);
    wr(8'h00, {1'b0, 1'b0, mode24, 5'b0});
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    rd(8'h00, 8'h00, "R1 ctrl");
    rd(8'h08, 8'h00, "R1 hold flags");
    expect_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R1 live");

    // R2: disabled counter does not move
    repeat (100) @(negedge clk);
    rd(8'h4C, 8'h00, "R2 run off sec");

    // R10 load with run off, R12 write bank readback
    load_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h14, 8'h05, 8'h24);
    expect_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h14, 8'h05, 8'h24, "R10 loaded");
    rd(8'h18, 8'h20, "R12 wbank min");
    rd(8'h2C, 8'h24, "R12 wbank year");

    // R9: pause while running
    wr(8'h00, 8'hA0);
    wr(8'h08, 8'h01);
    rd(8'h08, 8'h01, "R9 request only");
    repeat (12) @(negedge clk);
    rd(8'h08, 8'h03, "R9 acknowledged");
    repeat (200) @(negedge clk);
    rd(8'h4C, 8'h10, "R9 held sec");
    // R10: release restarts the second from zero
    wr(8'h08, 8'h00);
    rd(8'h08, 8'h00, "R10 flags cleared");
    repeat (SEC_CYC + 2) @(negedge clk);
    rd(8'h4C, 8'h11, "R10 one second after release");
    stop_run(1'b1);

    // R11: cancel before acknowledge
    wr(8'h14, 8'h33);
    wr(8'h08, 8'h01);
    wr(8'h08, 8'h00);
    rd(8'h08, 8'h00, "R11 flags");
    rd(8'h4C, 8'h11, "R11 no load");
    rd(8'h14, 8'h33, "R12 wbank sec");

    // R2: counting rate
    load_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    run_secs(1'b1, 3);
    rd(8'h4C, 8'h03, "R2 three seconds");
    stop_run(1'b1);

    // R3: minute carry
    load_time(8'h59, 8'h14, 8'h10, 8'h01, 8'h05, 8'h03, 8'h10);
    run_secs(1'b1, 1);
    expect_time(8'h00, 8'h15, 8'h10, 8'h01, 8'h05, 8'h03, 8'h10, "R3 minute carry");
    stop_run(1'b1);

    // R4 R6 R7 R8: end of century
    load_time(8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    run_secs(1'b1, 2);
    expect_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R4 R7 R8 year wrap");
    stop_run(1'b1);

    // R6: common February
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    run_secs(1'b1, 1);
    expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, "R6 Feb common");
    stop_run(1'b1);

    // R6: leap February
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    run_secs(1'b1, 1);
    expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24, "R6 Feb leap");
    stop_run(1'b1);

    // R6: year 00 is leap
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h00);
    run_secs(1'b1, 1);
    rd(8'h5C, 8'h29, "R6 year 00 leap day");
    stop_run(1'b1);

    // R6: thirty-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h15);
    run_secs(1'b1, 1);
    expect_time(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h05, 8'h15, "R6 April end");
    stop_run(1'b1);

    // R5: 12-hour format
    load_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h15, 8'h06, 8'h30);
    run_secs(1'b0, 1);
    expect_time(8'h00, 8'h00, 8'h32, 8'h02, 8'h15, 8'h06, 8'h30, "R5 noon");
    stop_run(1'b0);

    load_time(8'h59, 8'h59, 8'h31, 8'h02, 8'h15, 8'h06, 8'h30);
    run_secs(1'b0, 1);
    expect_time(8'h00, 8'h00, 8'h12, 8'h03, 8'h16, 8'h06, 8'h30, "R5 midnight");
    stop_run(1'b0);

    load_time(8'h59, 8'h59, 8'h12, 8'h02, 8'h15, 8'h06, 8'h30);
    run_secs(1'b0, 1);
    rd(8'h54, 8'h01, "R5 12 to 1");
    stop_run(1'b0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule